// File: doc/BRIEF.md
# Stereo Playback Attenuation Ramp with Zero-Run Mute

This block sits in a stereo playback datapath ahead of the interpolation filters. Each stereo frame it takes one signed left sample and one signed right sample, marked by a one-cycle frame strobe. It scales each sample by that channel's current attenuation and presents the two results one clock later.

The attenuation of each channel is not set directly. Each channel holds a current code that walks toward a target code. The target comes from the per-channel setting, from the shared setting when the channels are linked, or from silence when mute is in effect. The walk can be gradual or immediate, and it can be held back until the channel's signal crosses zero.

A run detector watches for long stretches of digital silence on both channels and mutes the path by itself. It releases on the first frame that carries any energy. A single flag reports when either the user mute or the automatic mute is active.

Top module: `vol_ramp_core`

## Requirements
- R1: With current code c (0 to 240, 0.5 dB per code), each output equals ((x >>> (c/12)) * M[c%12]) >>> 15, with M[k] = round(32768 * 10^(-k/40)). The output is registered on the frame strobe and uses the code in force before that strobe. out_stb pulses in the cycle after frame_stb.
- R2: A target code above 240 is treated as 240.
- R3: With soft ramp on, the current code moves by exactly one code toward its target on every P-th frame, where P = 4 << rate_sel (00→4, 01→8, 10→16, 11→32). Counting frames from 0 at the first frame after a target change, the output of frame n*P shows the n-th step. Between strobes the code does not change.
- R4: While mute is in effect, the target of both channels is the silence code 241, whose output is exactly 0. Fade-out and fade-back both follow R3 timing.
- R5: With soft ramp off, a changed target is taken whole at the first frame after the change. The output of the following frame shows it.
- R6: With zero-cross on, a pending change is applied only in a frame whose sample is zero or has the opposite sign to that channel's previous sample. After 1024 consecutive blocked frames it is applied anyway: with a change made just before frame 0 and no crossing, the output of frame 1024 shows it.
- R7: With link_lr set, both channels take att_l as their target, and att_r has no effect.
- R8: With amute_en set, the 8192nd consecutive frame whose samples are both zero sets the automatic mute. With amute_en clear, no run of zeros mutes.
- R9: A frame with any non-zero sample clears the automatic mute at that strobe.
- R10: mute_flag is high exactly while mute_req is high or the automatic mute is set.
- R11: After reset, both outputs are 0, out_stb and mute_flag are low, and both current codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe, one per stereo frame |
| in_l | input | 24 | Left sample, signed |
| in_r | input | 24 | Right sample, signed |
| att_l | input | 8 | Left target attenuation code |
| att_r | input | 8 | Right target attenuation code |
| mute_req | input | 1 | User mute |
| rate_sel | input | 2 | Frames-per-step select |
| soft_en | input | 1 | Gradual stepping enable |
| zc_en | input | 1 | Zero-cross gating enable |
| link_lr | input | 1 | Right channel follows left target |
| amute_en | input | 1 | Automatic mute enable |
| out_l | output | 24 | Scaled left sample, signed |
| out_r | output | 24 | Scaled right sample, signed |
| out_stb | output | 1 | Output valid strobe |
| mute_flag | output | 1 | Mute in effect |

## Verification
The bench goes after the step timing at each rate. A counter off by one frame would show the step one frame early or late. It also probes the boundary codes 11/12 and 240 of the shift-plus-multiplier law, where a wrong split of the code would scale by the wrong power of two. The zero-cross tests cover the crossing frame, the zero-sample frame and the timeout at frame 1024. A wrong timeout count would release early or never. The zero-run tests count exactly 8191 versus 8192 silent frames and check the release on a single non-zero sample. A design that cancelled late would keep outputting silence.

// File: rtl/vr_pkg.sv
// Shared constants and the fractional gain table of the attenuation ramp.
// Assumes 0.5 dB per code, so 12 codes make one power-of-two shift.
package vr_pkg;
    localparam int CODES_PER_SHIFT = 12;
    localparam int MULT_W          = 17;
    localparam int MULT_FRAC       = 15;

    // Q15 multiplier for the remaining 0..11 half-dB steps
    function automatic logic [MULT_W-1:0] frac_mult(input logic [3:0] k);
        case (k)
            4'd0:    frac_mult = 17'd32768;
            4'd1:    frac_mult = 17'd30935;
            4'd2:    frac_mult = 17'd29205;
            4'd3:    frac_mult = 17'd27571;
            4'd4:    frac_mult = 17'd26029;
            4'd5:    frac_mult = 17'd24573;
            4'd6:    frac_mult = 17'd23198;
            4'd7:    frac_mult = 17'd21900;
            4'd8:    frac_mult = 17'd20675;
            4'd9:    frac_mult = 17'd19519;
            4'd10:   frac_mult = 17'd18427;
            4'd11:   frac_mult = 17'd17396;
            default: frac_mult = 17'd32768;
        endcase
    endfunction
endpackage

// File: rtl/vr_stepper.sv
// Walks one channel's current attenuation code toward its target.
// Steps once per frames-per-step period (soft) or jumps (hard).
// When zero-cross gating is on, a change waits for a sign change or a
// zero sample, with a timeout. Assumes frame_stb is a one-cycle pulse.
module vr_stepper #(
    parameter int DATA_W     = 24,
    parameter int CODE_W     = 8,
    parameter int RATE_W     = 2,
    parameter int BASE_LOG2  = 2,
    parameter int ZC_TIMEOUT = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_stb,
    input  logic signed [DATA_W-1:0] sample,
    input  logic [CODE_W-1:0]        tgt,
    input  logic [RATE_W-1:0]        rate_sel,
    input  logic                     soft_en,
    input  logic                     zc_en,
    output logic [CODE_W-1:0]        cur
);
    localparam int CNT_W  = BASE_LOG2 + (1 << RATE_W) - 1;
    localparam int WAIT_W = $clog2(ZC_TIMEOUT);

    logic [CNT_W-1:0]  rate_cnt;
    logic [WAIT_W-1:0] zc_wait;
    logic              prev_neg;
    logic [CNT_W-1:0]  period_m1;
    logic              pending, due, zero_cross, gate_ok;
    logic [CODE_W-1:0] next_code;

    // Decode the step period and the gating conditions for this frame
    always_comb begin
        period_m1  = CNT_W'((1 << (BASE_LOG2 + int'(rate_sel))) - 1);
        pending    = (cur != tgt);
        due        = !soft_en || (rate_cnt >= period_m1);
        zero_cross = (sample == '0) || (sample[DATA_W-1] != prev_neg);
        gate_ok    = !zc_en || zero_cross || (zc_wait == WAIT_W'(ZC_TIMEOUT - 1));
        if (!soft_en)
            next_code = tgt;
        else if (cur < tgt)
            next_code = cur + CODE_W'(1);
        else
            next_code = cur - CODE_W'(1);
    end

    // Advance period counter, crossing wait counter and code once per frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= '0;
            rate_cnt <= '0;
            zc_wait  <= '0;
            prev_neg <= 1'b0;
        end else if (frame_stb) begin
            prev_neg <= sample[DATA_W-1];
            if (!pending) begin
                rate_cnt <= '0;
                zc_wait  <= '0;
            end else if (!due) begin
                rate_cnt <= rate_cnt + CNT_W'(1);
            end else if (gate_ok) begin
                cur      <= next_code;
                rate_cnt <= '0;
                zc_wait  <= '0;
            end else begin
                zc_wait  <= zc_wait + WAIT_W'(1);
            end
        end
    end

    AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(cur)); // R3
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && soft_en) |=>
        (cur == $past(cur) || cur == $past(cur) + CODE_W'(1) || cur == $past(cur) - CODE_W'(1))); // R3
    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && cur < tgt) |=> cur <= $past(tgt)); // R3
    AST_BLOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && zc_en && sample != '0 && sample[DATA_W-1] == prev_neg && zc_wait == '0)
        |=> $stable(cur)); // R6
endmodule

// File: rtl/vr_scaler.sv
// Applies an attenuation code to one sample: an arithmetic shift for
// every 12 codes, then a Q15 multiply for the remainder. Codes at or
// above the silence code give zero. Output is registered on frame_stb.
module vr_scaler #(
    parameter int DATA_W     = 24,
    parameter int CODE_W     = 8,
    parameter int FLOOR_CODE = 241
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_stb,
    input  logic signed [DATA_W-1:0] sample,
    input  logic [CODE_W-1:0]        code,
    output logic signed [DATA_W-1:0] out
);
    import vr_pkg::*;
    localparam int PROD_W = DATA_W + MULT_W + 1;

    logic [CODE_W-1:0]          shift_amt;
    logic [3:0]                 frac;
    logic signed [DATA_W-1:0]   shifted;
    logic signed [MULT_W:0]     mult_s;
    logic signed [PROD_W-1:0]   prod, prod_sh;
    logic signed [DATA_W-1:0]   scaled;

    // Split the code, shift, multiply and rescale
    always_comb begin
        shift_amt = code / CODE_W'(CODES_PER_SHIFT);
        frac      = 4'(code % CODE_W'(CODES_PER_SHIFT));
        shifted   = sample >>> shift_amt;
        mult_s    = {1'b0, frac_mult(frac)};
        prod      = shifted * mult_s;
        prod_sh   = prod >>> MULT_FRAC;
        scaled    = (code >= CODE_W'(FLOOR_CODE)) ? '0 : prod_sh[DATA_W-1:0];
    end

    // Register the scaled sample on each frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            out <= '0;
        else if (frame_stb)
            out <= scaled;
    end

    AST_SILENT_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && code == CODE_W'(FLOOR_CODE)) |=> out == '0); // R4
    AST_UNITY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && code == '0) |=> out == $past(sample)); // R1
endmodule

// File: rtl/vr_zero_watch.sv
// Counts consecutive stereo frames with both samples zero. It sets the
// automatic mute on the RUN_LEN-th such frame and clears it on any
// non-zero sample or when disabled.
module vr_zero_watch #(
    parameter int DATA_W  = 24,
    parameter int RUN_LEN = 8192
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_stb,
    input  logic signed [DATA_W-1:0] smp_l,
    input  logic signed [DATA_W-1:0] smp_r,
    input  logic                     enable,
    output logic                     amute
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);

    logic [RUN_W-1:0] run_cnt;
    logic             silent;

    assign silent = (smp_l == '0) && (smp_r == '0);

    // Track the silent run length and the resulting mute state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            amute   <= 1'b0;
        end else begin
            if (!enable)
                amute <= 1'b0;
            if (frame_stb) begin
                if (!silent) begin
                    run_cnt <= '0;
                    amute   <= 1'b0;
                end else begin
                    if (run_cnt != RUN_W'(RUN_LEN))
                        run_cnt <= run_cnt + RUN_W'(1);
                    if (enable && run_cnt >= RUN_W'(RUN_LEN - 1))
                        amute <= 1'b1;
                end
            end
        end
    end

    AST_NONZERO_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !silent) |=> !amute); // R9
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !amute); // R8
endmodule

// File: rtl/vol_ramp_core.sv
// Stereo attenuation ramp. It forms each channel's effective target from
// the link, clamp and mute settings, walks the current codes, scales the
// samples and detects long zero runs. Assumes one frame_stb pulse per
// stereo frame with in_l/in_r valid in that cycle.
module vol_ramp_core #(
    parameter int DATA_W     = 24,
    parameter int CODE_W     = 8,
    parameter int MAX_CODE   = 240,
    parameter int RATE_W     = 2,
    parameter int BASE_LOG2  = 2,
    parameter int ZC_TIMEOUT = 1024,
    parameter int ZERO_RUN   = 8192
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_stb,
    input  logic signed [DATA_W-1:0] in_l,
    input  logic signed [DATA_W-1:0] in_r,
    input  logic [CODE_W-1:0]        att_l,
    input  logic [CODE_W-1:0]        att_r,
    input  logic                     mute_req,
    input  logic [RATE_W-1:0]        rate_sel,
    input  logic                     soft_en,
    input  logic                     zc_en,
    input  logic                     link_lr,
    input  logic                     amute_en,
    output logic signed [DATA_W-1:0] out_l,
    output logic signed [DATA_W-1:0] out_r,
    output logic                     out_stb,
    output logic                     mute_flag
);
    localparam int FLOOR_CODE = MAX_CODE + 1;
    localparam int NUM_CH     = 2;

    logic                     amute;
    logic                     mute_eff;
    logic signed [DATA_W-1:0] smp   [NUM_CH];
    logic signed [DATA_W-1:0] res   [NUM_CH];
    logic [CODE_W-1:0]        code  [NUM_CH];

    assign smp[0]    = in_l;
    assign smp[1]    = in_r;
    assign out_l     = res[0];
    assign out_r     = res[1];
    assign mute_eff  = mute_req | amute;
    assign mute_flag = mute_eff;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [CODE_W-1:0] raw, tgt;

        // Choose the source setting, clamp it, and override with silence on mute
        always_comb begin
            raw = (ch == 0 || link_lr) ? att_l : att_r;
            if (raw > CODE_W'(MAX_CODE))
                raw = CODE_W'(MAX_CODE);
            tgt = mute_eff ? CODE_W'(FLOOR_CODE) : raw;
        end

        vr_stepper #(
            .DATA_W(DATA_W), .CODE_W(CODE_W), .RATE_W(RATE_W),
            .BASE_LOG2(BASE_LOG2), .ZC_TIMEOUT(ZC_TIMEOUT)
        ) u_step (
            .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
            .sample(smp[ch]), .tgt(tgt), .rate_sel(rate_sel),
            .soft_en(soft_en), .zc_en(zc_en), .cur(code[ch])
        );

        vr_scaler #(
            .DATA_W(DATA_W), .CODE_W(CODE_W), .FLOOR_CODE(FLOOR_CODE)
        ) u_scale (
            .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
            .sample(smp[ch]), .code(code[ch]), .out(res[ch])
        );
    end

    vr_zero_watch #(.DATA_W(DATA_W), .RUN_LEN(ZERO_RUN)) u_zero (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .smp_l(in_l), .smp_r(in_r), .enable(amute_en), .amute(amute)
    );

    // Mark output validity one cycle after each frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_stb <= 1'b0;
        else
            out_stb <= frame_stb;
    end

    AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> (code[0] <= CODE_W'(FLOOR_CODE) && code[1] <= CODE_W'(FLOOR_CODE))); // R2
    AST_LINKED_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (link_lr && frame_stb && code[0] == code[1] && !soft_en && !zc_en) |=> code[0] == code[1]); // R7
endmodule

// File: tb/vol_ramp_core_bench.sv
module vol_ramp_core_bench;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               frame_stb = 1'b0;
    logic signed [23:0] in_l = '0, in_r = '0;
    logic [7:0]         att_l = '0, att_r = '0;
    logic               mute_req = 1'b0;
    logic [1:0]         rate_sel = '0;
    logic               soft_en = 1'b0, zc_en = 1'b0, link_lr = 1'b0, amute_en = 1'b0;
    logic signed [23:0] out_l, out_r;
    logic               out_stb, mute_flag;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    q_l[$];
    int    q_r[$];
    string q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vol_ramp_core u_vol_ramp_core (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .in_l(in_l), .in_r(in_r),
        .att_l(att_l), .att_r(att_r), .mute_req(mute_req), .rate_sel(rate_sel),
        .soft_en(soft_en), .zc_en(zc_en), .link_lr(link_lr), .amute_en(amute_en),
        .out_l(out_l), .out_r(out_r), .out_stb(out_stb), .mute_flag(mute_flag)
    );

    // Expected scaled value from the gain law of R1/R4
    function automatic int scale(int x, int c);
        real     m;
        longint  s, p;
        if (c > 240) return 0;
        m = 32768.0 * (10.0 ** (-(c % 12) / 40.0));
        s = longint'(x) >>> (c / 12);
        p = s * longint'($rtoi(m + 0.5));
        return int'(p >>> 15);
    endfunction

    // Expected code f frames after a target change with period p (R3)
    function automatic int ramp(int s, int t, int f, int p);
        int n;
        n = f / p;
        if (t >= s) return (s + n > t) ? t : s + n;
        return (s - n < t) ? t : s - n;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: push expected result, then present one frame over 4 cycles
    task automatic send_frame(int xl, int xr, int cl, int cr, string req);
        q_l.push_back(scale(xl, cl));
        q_r.push_back(scale(xr, cr));
        q_tag.push_back(req);
        @(negedge clk);
        in_l = 24'(xl); in_r = 24'(xr); frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare each produced frame with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && out_stb) begin
            if (q_l.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R1 unexpected out_stb actual=1 expected=0");
            end else begin
                string t;
                int el, er;
                el = q_l.pop_front(); er = q_r.pop_front(); t = q_tag.pop_front();
                check({t, " left"}, int'(out_l), el);
                check({t, " right"}, int'(out_r), er);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int pl, pr, cl, cr;
        int codes[9] = '{0, 1, 5, 11, 12, 23, 100, 200, 240};
        int xs[5]    = '{8388607, -8388608, 1234567, -1, -777777};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 out_l", int'(out_l), 0);
        check("R11 out_r", int'(out_r), 0);
        check("R11 out_stb", int'(out_stb), 0);
        check("R11 mute_flag", int'(mute_flag), 0);
        send_frame(4000000, -4000000, 0, 0, "R11 unity");

        // R1/R5: hard jumps across codes and sample patterns
        pl = 0; pr = 0;
        foreach (codes[i]) begin
            att_l = 8'(codes[i]); att_r = 8'(240 - codes[i]);
            send_frame(xs[0], xs[1], pl, pr, "R5 old code");
            for (int k = 0; k < 5; k++)
                send_frame(xs[k], xs[4 - k], codes[i], 240 - codes[i], "R1");
            pl = codes[i]; pr = 240 - codes[i];
        end

        // R2: clamp above 240
        att_l = 8'd255; att_r = 8'd241;
        send_frame(8388607, -8388608, pl, pr, "R2");
        send_frame(8388607, -8388608, 240, 240, "R2");
        send_frame(8388607, 8388607, 240, 240, "R2");
        att_l = 0; att_r = 0;
        send_frame(100, 100, 240, 240, "R5");
        send_frame(4000000, 4000000, 0, 0, "R5");

        // R3: soft ramps at several rates
        soft_en = 1'b1; rate_sel = 2'd0; att_l = 8'd6; att_r = 8'd3;
        for (int f = 0; f < 30; f++)
            send_frame(1000000, -3000000, ramp(0, 6, f, 4), ramp(0, 3, f, 4), "R3 rate0");
        rate_sel = 2'd2; att_l = 8'd0; att_r = 8'd5;
        for (int f = 0; f < 100; f++)
            send_frame(1000000, -3000000, ramp(6, 0, f, 16), ramp(3, 5, f, 16), "R3 rate2");
        rate_sel = 2'd3; att_l = 8'd2;
        for (int f = 0; f < 70; f++)
            send_frame(2000000, 3000000, ramp(0, 2, f, 32), 5, "R3 rate3");

        // R4/R10: mute fade out and back
        rate_sel = 2'd0; mute_req = 1'b1;
        @(negedge clk);
        check("R10 mute_flag user", int'(mute_flag), 1);
        for (int f = 0; f < 1000; f++)
            send_frame(5000000, -5000000, ramp(2, 241, f, 4), ramp(5, 241, f, 4), "R4 fade out");
        mute_req = 1'b0;
        @(negedge clk);
        check("R10 mute_flag released", int'(mute_flag), 0);
        for (int f = 0; f < 1000; f++)
            send_frame(5000000, -5000000, ramp(241, 2, f, 4), ramp(241, 5, f, 4), "R4 fade in");

        // R5: hard mute and unmute
        soft_en = 1'b0; mute_req = 1'b1;
        send_frame(6000000, 6000000, 2, 5, "R5 mute");
        send_frame(6000000, 6000000, 241, 241, "R5 mute");
        mute_req = 1'b0;
        send_frame(6000000, 6000000, 241, 241, "R5 unmute");
        send_frame(6000000, 6000000, 2, 5, "R5 unmute");

        // R6: zero-cross gating, sign change, timeout and zero sample
        zc_en = 1'b1;
        send_frame(1000000, 1000000, 2, 5, "R6 prime");
        send_frame(1000000, 1000000, 2, 5, "R6 prime");
        att_l = 8'd24; att_r = 8'd24;
        for (int f = 0; f < 1030; f++) begin
            cl = (f < 1024) ? 2 : 24;
            cr = (f <= 5) ? 5 : 24;
            send_frame(1000000, (f < 5) ? 1000000 : -2000000, cl, cr, "R6 cross/timeout");
        end
        att_l = 8'd30;
        for (int f = 0; f < 8; f++)
            send_frame((f == 3) ? 0 : 500000, -2000000, (f <= 3) ? 24 : 30, 24, "R6 zero sample");
        zc_en = 1'b0;

        // R7: linked channels, right setting ignored
        link_lr = 1'b1; att_l = 8'd40; att_r = 8'd90;
        send_frame(3000000, 3000000, 30, 24, "R7");
        send_frame(3000000, 3000000, 40, 40, "R7");
        att_r = 8'd200;
        send_frame(3000000, -3000000, 40, 40, "R7 ignored");
        send_frame(3000000, -3000000, 40, 40, "R7 ignored");
        link_lr = 1'b0; att_l = 0; att_r = 0;
        send_frame(1000, 1000, 40, 40, "R7 unlink");
        send_frame(1000, 1000, 0, 0, "R7 unlink");

        // R8/R9/R10: automatic mute on zero run
        amute_en = 1'b1;
        for (int f = 0; f < 8191; f++)
            send_frame(0, 0, 0, 0, "R8 run");
        check("R8 not yet muted at 8191", int'(mute_flag), 0);
        send_frame(0, 0, 0, 0, "R8 run");
        check("R8 muted at 8192", int'(mute_flag), 1);
        for (int f = 0; f < 3; f++)
            send_frame(0, 0, 241, 241, "R8 muted");
        send_frame(3000000, 0, 241, 241, "R9 cancel frame");
        check("R9 mute_flag cleared", int'(mute_flag), 0);
        send_frame(3000000, 0, 241, 241, "R9 returning");
        send_frame(3000000, -3000000, 0, 0, "R9 restored");

        amute_en = 1'b0;
        for (int f = 0; f < 8200; f++)
            send_frame(0, 0, 0, 0, "R8 disabled run");
        check("R8 disabled no mute", int'(mute_flag), 0);
        send_frame(7000000, -7000000, 0, 0, "R8 disabled passes");

        repeat (4) @(negedge clk);
        check("R1 scoreboard drained", q_l.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule